// File: doc/BRIEF.md
# Memory Test Traffic Sequencer

This block produces the command stream for a memory stress test. Once started, it runs a number of loops. Each loop is one block: a run of write commands and then a run of read commands. The reads go back to the locations that the same block wrote. Every command leaves on a valid/ready command port as a direction bit and a 25-bit word address. Data patterns, read-data checking and device timing belong to neighbouring blocks.

The configuration inputs are captured on the start request, so they may change freely during a run. Addresses normally advance one word per unique write, and that advance carries on across loops. As an option, every loop can restart at the programmed start address. Four address fields can be frozen one by one: the bank group, the bank, the row and the rank. A frozen field keeps the value it has in the start address, while the underlying linear walk continues. The block raises `busy` for the length of a run and gives a single-cycle `done` when the run ends.

Top module: `mem_traffic_seq`

## Requirements
- R1: When `start` is high while the block is idle, the block captures all configuration inputs and raises `busy` on the next cycle. From that cycle it presents a write to the start address (after masking).
- R2: In every block, `wr_per_blk` unique write addresses are issued before any read. They are the block base address plus 0, 1, 2 and so on. Each address is accepted `wr_rep` times in a row before the next one.
- R3: After the writes, the block issues `rd_per_blk` reads. Read number i (counting from 0) goes to the block base plus (i mod `wr_per_blk`). This covers two cases: when reads outnumber writes the address wraps back to the base, and when there are fewer reads only the first ones are revisited. Each read address is accepted `rd_rep` times in a row.
- R4: A run has `loops` blocks. When `ret_start` is 0, each block base is the previous base plus `wr_per_blk`. When `ret_start` is 1, each block base is the start address.
- R5: Address arithmetic is modulo 2^25, so the address after 0x1FFFFFF is 0.
- R6: Address layout, from the least significant bit upward: column [9:0], bank group [11:10], bank [13:12], row [23:14], rank [24]. Bits of `cfg_field_mask` are: bit 0 bank group, bit 1 bank, bit 2 row, bit 3 rank. A masked field carries the start address's value for that field. All other bits follow the linear address.
- R7: A command counts only on a cycle where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, the command direction and address stay unchanged.
- R8: `done` is high for exactly one cycle: the cycle after the last read of the last loop is accepted. In that cycle, and from then on until the next start, `busy` and `cmd_valid` are low.
- R9: A `start` request while `busy` is high is ignored. The running command stream continues with its original configuration.
- R10: A configuration value of 0 for loops, writes per block, reads per block, write repeats or read repeats is treated as 1.
- R11: After reset, `busy`, `done` and `cmd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, accepted only when idle |
| cfg_loops | input | 12 | Number of blocks in a run |
| cfg_wr_per_blk | input | 12 | Unique write addresses per block |
| cfg_rd_per_blk | input | 12 | Read addresses per block |
| cfg_wr_rep | input | 8 | Consecutive issues of each write |
| cfg_rd_rep | input | 8 | Consecutive issues of each read |
| cfg_start_addr | input | 25 | First address of the run |
| cfg_ret_start | input | 1 | 1: every block restarts at the start address |
| cfg_field_mask | input | 4 | Freeze enables for bank group, bank, row, rank |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Command port accepts this cycle |
| cmd_write | output | 1 | 1 write, 0 read |
| cmd_addr | output | 25 | Command word address |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench uses the default parameters: a 25-bit address, 12-bit block and loop counters, 8-bit repeat counters, and field widths of 10/2/2/10/1 for column, bank group, bank, row and rank. With these widths, a start address a few words below 0x1FFFFFF exercises the wrap to zero. A start address just below a column boundary lets the linear walk carry into the bank-group bits, so masking that field shows the freeze. The 8-bit repeat width allows a directed run with 255 back-to-back reads of a single location. Several hundred writes per block push the offset counters far beyond the short random runs.

// File: rtl/mts_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the memory test traffic sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package mts_pkg;

    // Phase of the sequencer: idle, write half of a block, read half
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2
    } mts_state_e;

    // Number of address fields that can be frozen
    localparam int NUM_FIELDS = 4;

    // Bit index of each freeze enable inside the field mask input
    localparam int FLD_BG   = 0;
    localparam int FLD_BANK = 1;
    localparam int FLD_ROW  = 2;
    localparam int FLD_RANK = 3;

endpackage

// File: rtl/mts_step_counter.sv
`timescale 1ns/1ps
// Module: mts_step_counter
// Counts up from 0 to a programmable last value. After the last value it
// wraps to 0 on the next increment. It flags when the count equals the
// last value.
// Assumes: last_val changes only while the count is 0 or while the counter
// is being cleared. clr takes priority over inc.
module mts_step_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] count,
    output logic         at_last
);

    // Terminal flag compares the running count against the limit
    assign at_last = (count == last_val);

    // Count register: clear, or step with wrap at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= at_last ? '0 : count + W'(1);
        end
    end

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count <= last_val));

endmodule

// File: rtl/mts_addr_mask.sv
`timescale 1ns/1ps
// Module: mts_addr_mask
// Builds the command address from the linear address. Each enabled field
// (bank group, bank, row, rank) takes the start address's bits, and every
// other bit follows the linear address.
// Assumes: the layout from the least significant bit is column, bank group,
// bank, row, rank, and the field widths add up to at most ADDR_W.
module mts_addr_mask
    import mts_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 10,
    parameter int RANK_W = 1
) (
    input  logic [ADDR_W-1:0]     lin_addr,
    input  logic [ADDR_W-1:0]     base_ref,
    input  logic [NUM_FIELDS-1:0] mask_en,
    output logic [ADDR_W-1:0]     out_addr
);

    localparam int LO_BG   = COL_W;
    localparam int LO_BANK = LO_BG + BG_W;
    localparam int LO_ROW  = LO_BANK + BANK_W;
    localparam int LO_RANK = LO_ROW + ROW_W;

    localparam int FLD_LO [NUM_FIELDS] = '{LO_BG, LO_BANK, LO_ROW, LO_RANK};
    localparam int FLD_WD [NUM_FIELDS] = '{BG_W, BANK_W, ROW_W, RANK_W};

    logic [ADDR_W-1:0] fld_mask [NUM_FIELDS];
    logic [ADDR_W-1:0] frozen;

    // One constant bit mask per field, gated by its enable
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        localparam logic [ADDR_W-1:0] FM =
            ADDR_W'(((64'd1 << FLD_WD[f]) - 64'd1) << FLD_LO[f]);
        assign fld_mask[f] = mask_en[f] ? FM : '0;
    end

    // Merge the enabled field masks into one frozen-bit vector
    always_comb begin
        frozen = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            frozen = frozen | fld_mask[i];
        end
    end

    // Frozen bits come from the start address, the rest from the walk
    assign out_addr = (lin_addr & ~frozen) | (base_ref & frozen);

endmodule

// File: rtl/mem_traffic_seq.sv
`timescale 1ns/1ps
// Module: mem_traffic_seq (top)
// Sequences the write-then-read blocks of a memory test run on a
// valid/ready command port. It nests three levels of counting: loops,
// addresses within a block, and repeats of each address. Reads revisit the
// block's write addresses by offset from the block base.
// Assumes: the downstream port may hold cmd_ready low for any number of
// cycles. Configuration is sampled only when a start is accepted.
module mem_traffic_seq
    import mts_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int CNT_W  = 12,
    parameter int REP_W  = 8,
    parameter int COL_W  = 10,
    parameter int BG_W   = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 10,
    parameter int RANK_W = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [CNT_W-1:0]      cfg_loops,
    input  logic [CNT_W-1:0]      cfg_wr_per_blk,
    input  logic [CNT_W-1:0]      cfg_rd_per_blk,
    input  logic [REP_W-1:0]      cfg_wr_rep,
    input  logic [REP_W-1:0]      cfg_rd_rep,
    input  logic [ADDR_W-1:0]     cfg_start_addr,
    input  logic                  cfg_ret_start,
    input  logic [NUM_FIELDS-1:0] cfg_field_mask,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic                  cmd_write,
    output logic [ADDR_W-1:0]     cmd_addr,
    output logic                  busy,
    output logic                  done
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

    // Captured configuration
    logic [CNT_W-1:0]      loops_q, wpb_q, rpb_q;
    logic [REP_W-1:0]      wrep_q, rrep_q;
    logic [ADDR_W-1:0]     start_q;
    logic                  ret_q;
    logic [NUM_FIELDS-1:0] mask_q;

    mts_state_e        state_q;
    logic [ADDR_W-1:0] base_q;
    logic              done_q;

    logic go, acc, in_wr, in_rd;
    logic item_done, wr_item, rd_item, loop_end, finish;
    logic [REP_W-1:0] rep_last_val, rep_cnt;
    logic [CNT_W-1:0] wr_idx, rd_cnt, rd_off, loop_cnt;
    logic rep_at_last, wr_at_last, rd_at_last, rd_off_last, loop_at_last;
    logic [ADDR_W-1:0] lin_addr;

    // Handshake and phase decode
    assign go        = start && (state_q == ST_IDLE);
    assign in_wr     = (state_q == ST_WR);
    assign in_rd     = (state_q == ST_RD);
    assign acc       = cmd_valid && cmd_ready;
    assign item_done = acc && rep_at_last;
    assign wr_item   = item_done && in_wr;
    assign rd_item   = item_done && in_rd;
    assign loop_end  = rd_item && rd_at_last;
    assign finish    = loop_end && loop_at_last;

    // The repeat limit follows the current phase
    assign rep_last_val = in_wr ? (wrep_q - REP_ONE) : (rrep_q - REP_ONE);

    // Configuration capture on an accepted start, with zero taken as one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loops_q <= '0;
            wpb_q   <= '0;
            rpb_q   <= '0;
            wrep_q  <= '0;
            rrep_q  <= '0;
            start_q <= '0;
            ret_q   <= 1'b0;
            mask_q  <= '0;
        end else if (go) begin
            loops_q <= (cfg_loops      == '0) ? CNT_ONE : cfg_loops;
            wpb_q   <= (cfg_wr_per_blk == '0) ? CNT_ONE : cfg_wr_per_blk;
            rpb_q   <= (cfg_rd_per_blk == '0) ? CNT_ONE : cfg_rd_per_blk;
            wrep_q  <= (cfg_wr_rep     == '0) ? REP_ONE : cfg_wr_rep;
            rrep_q  <= (cfg_rd_rep     == '0) ? REP_ONE : cfg_rd_rep;
            start_q <= cfg_start_addr;
            ret_q   <= cfg_ret_start;
            mask_q  <= cfg_field_mask;
        end
    end

    // Phase sequencing: idle -> writes -> reads -> writes ... -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (go) begin
            state_q <= ST_WR;
        end else if (wr_item && wr_at_last) begin
            state_q <= ST_RD;
        end else if (loop_end) begin
            state_q <= finish ? ST_IDLE : ST_WR;
        end
    end

    // Block base: loaded at start, then advanced or rewound per loop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (go) begin
            base_q <= cfg_start_addr;
        end else if (loop_end && !finish) begin
            base_q <= ret_q ? start_q : base_q + ADDR_W'(wpb_q);
        end
    end

    // End-of-run pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
        end
    end

    // Repeats of the current address
    mts_step_counter #(.W(REP_W)) u_rep_cnt (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(acc),
        .last_val(rep_last_val), .count(rep_cnt), .at_last(rep_at_last)
    );

    // Unique write index within the block
    mts_step_counter #(.W(CNT_W)) u_wr_cnt (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(wr_item),
        .last_val(wpb_q - CNT_ONE), .count(wr_idx), .at_last(wr_at_last)
    );

    // Read item count within the block
    mts_step_counter #(.W(CNT_W)) u_rd_cnt (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(rd_item),
        .last_val(rpb_q - CNT_ONE), .count(rd_cnt), .at_last(rd_at_last)
    );

    // Read offset into the written range, wrapping at writes per block
    mts_step_counter #(.W(CNT_W)) u_rd_off (
        .clk(clk), .rst_n(rst_n), .clr(go || loop_end), .inc(rd_item),
        .last_val(wpb_q - CNT_ONE), .count(rd_off), .at_last(rd_off_last)
    );

    // Loop count within the run
    mts_step_counter #(.W(CNT_W)) u_loop_cnt (
        .clk(clk), .rst_n(rst_n), .clr(go), .inc(loop_end),
        .last_val(loops_q - CNT_ONE), .count(loop_cnt), .at_last(loop_at_last)
    );

    // Linear address of the current command
    assign lin_addr = base_q + ADDR_W'(in_wr ? wr_idx : rd_off);

    // Field freezing on the way out
    mts_addr_mask #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .BG_W(BG_W),
        .BANK_W(BANK_W), .ROW_W(ROW_W), .RANK_W(RANK_W)
    ) u_mask (
        .lin_addr(lin_addr), .base_ref(start_q),
        .mask_en(mask_q), .out_addr(cmd_addr)
    );

    assign cmd_valid = (state_q != ST_IDLE);
    assign cmd_write = in_wr;
    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_write));

    // R7
    rep_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> rep_cnt == $past(rep_cnt));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !cmd_valid);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(start_q) && $stable(loops_q) && $stable(wpb_q));

    // R10
    cfg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (loops_q != '0) && (wpb_q != '0) && (rpb_q != '0) &&
                 (wrep_q != '0) && (rrep_q != '0));

    // R4
    loop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> loop_cnt < loops_q);

    // R3
    rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_cnt < rpb_q);

    // R3
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_item && rd_off_last && !loop_end |=> rd_off == '0);

endmodule

// File: tb/mem_traffic_seq_tb.sv
`timescale 1ns/1ps
module mem_traffic_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] cfg_loops = '0, cfg_wr_per_blk = '0, cfg_rd_per_blk = '0;
    logic [7:0]  cfg_wr_rep = '0, cfg_rd_rep = '0;
    logic [24:0] cfg_start_addr = '0;
    logic        cfg_ret_start = 1'b0;
    logic [3:0]  cfg_field_mask = '0;
    logic        cmd_ready = 1'b0;
    logic        cmd_valid, cmd_write, busy, done;
    logic [24:0] cmd_addr;

    int checks = 0;
    int fails = 0;
    int n_cmds = 0;
    int poke_at = -1;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mem_traffic_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_loops(cfg_loops), .cfg_wr_per_blk(cfg_wr_per_blk),
        .cfg_rd_per_blk(cfg_rd_per_blk), .cfg_wr_rep(cfg_wr_rep),
        .cfg_rd_rep(cfg_rd_rep), .cfg_start_addr(cfg_start_addr),
        .cfg_ret_start(cfg_ret_start), .cfg_field_mask(cfg_field_mask),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Expected address from the R6 layout: bg [11:10], bank [13:12], row [23:14], rank [24]
    function automatic logic [24:0] exp_addr(input logic [24:0] lin,
                                             input logic [24:0] st,
                                             input logic [3:0] m);
        logic [24:0] f;
        f = '0;
        if (m[0]) f[11:10] = 2'b11;
        if (m[1]) f[13:12] = 2'b11;
        if (m[2]) f[23:14] = '1;
        if (m[3]) f[24]    = 1'b1;
        return (lin & ~f) | (st & f);
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Waits for one accepted command under random back-pressure and compares it
    task automatic expect_cmd(input bit exp_wr, input logic [24:0] exp_a, input string req);
        bit got;
        bit stalled;
        logic [24:0] ha;
        logic hw;
        got = 0;
        if (n_cmds == poke_at) begin
            start = 1'b1;                 // R9: request while busy
            cfg_loops = 12'd9;
            cfg_wr_per_blk = 12'd7;
            cfg_start_addr = 25'h0ABCDE;
        end
        while (!got) begin
            cmd_ready = ($urandom_range(3) != 0);
            if (cmd_valid && cmd_ready) begin
                chk(cmd_write == exp_wr, req, "direction", 32'(cmd_write), 32'(exp_wr));
                chk(cmd_addr == exp_a, req, "address", 32'(cmd_addr), 32'(exp_a));
                got = 1;
            end else begin
                stalled = cmd_valid;
                ha = cmd_addr;
                hw = cmd_write;
                @(negedge clk);
                if (stalled)
                    chk(cmd_valid && cmd_addr == ha && cmd_write == hw, "R7",
                        "held command", 32'(cmd_addr), 32'(ha));
            end
        end
        @(negedge clk);
        start = 1'b0;
        n_cmds++;
    endtask

    // Runs one configuration and walks the expected command stream
    task automatic run_case(input int loops, input int wpb, input int rpb,
                            input int wrep, input int rrep, input logic [24:0] st,
                            input bit ret, input logic [3:0] m, input int poke);
        logic [24:0] base;
        int el, ew, er, ewr, err;
        @(negedge clk);
        cfg_loops = 12'(loops); cfg_wr_per_blk = 12'(wpb); cfg_rd_per_blk = 12'(rpb);
        cfg_wr_rep = 8'(wrep); cfg_rd_rep = 8'(rrep); cfg_start_addr = st;
        cfg_ret_start = ret; cfg_field_mask = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && cmd_valid, "R1", "busy after start", 32'(busy), 32'd1);
        chk(cmd_write && cmd_addr == exp_addr(st, st, m), "R1", "first command",
            32'(cmd_addr), 32'(exp_addr(st, st, m)));
        el = eff(loops); ew = eff(wpb); er = eff(rpb); ewr = eff(wrep); err = eff(rrep);
        n_cmds = 0;
        poke_at = poke;
        base = st;
        for (int l = 0; l < el; l++) begin
            for (int w = 0; w < ew; w++)
                for (int k = 0; k < ewr; k++)
                    expect_cmd(1'b1, exp_addr(base + 25'(w), st, m), "R2");
            for (int i = 0; i < er; i++)
                for (int k = 0; k < err; k++)
                    expect_cmd(1'b0, exp_addr(base + 25'(i % ew), st, m), "R3");
            base = ret ? st : base + 25'(ew);   // R4, R5
        end
        poke_at = -1;
        cmd_ready = 1'b0;
        chk(done && !busy && !cmd_valid, "R8", "done after last read",
            {29'd0, done, busy, cmd_valid}, 32'h4);
        @(negedge clk);
        chk(!done && !busy && !cmd_valid, "R8", "done one cycle",
            {29'd0, done, busy, cmd_valid}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R11", "reset outputs",
            {29'd0, busy, done, cmd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !cmd_valid, "R11", "idle after reset",
            {29'd0, busy, done, cmd_valid}, 32'h0);
        // R2 R3 R4 basic advancing walk
        run_case(2, 3, 3, 1, 1, 25'h100, 1'b0, 4'h0, -1);
        // R3 many repeats of one location, R4 rewind
        run_case(2, 1, 1, 1, 255, 25'h1234, 1'b1, 4'h0, -1);
        // R3 more reads than writes, wrap to block base
        run_case(2, 2, 5, 2, 2, 25'h40, 1'b0, 4'h0, -1);
        // R3 fewer reads than writes
        run_case(2, 5, 2, 1, 1, 25'h800, 1'b0, 4'h0, -1);
        // R5 wrap past the top address
        run_case(2, 3, 4, 1, 1, 25'h1FFFFFE, 1'b0, 4'h0, -1);
        // R6 all fields frozen
        run_case(3, 5, 5, 1, 1, 25'h1ABCDEF, 1'b0, 4'hF, -1);
        // R6 bank group frozen across a column carry
        run_case(2, 4, 4, 1, 1, 25'h3FE, 1'b0, 4'h1, -1);
        // R6 row frozen, rank free
        run_case(1, 6, 3, 1, 2, 25'h0FFFFFD, 1'b0, 4'h4, -1);
        // R10 all zero configuration
        run_case(0, 0, 0, 0, 0, 25'h777, 1'b0, 4'h0, -1);
        // R9 start while busy
        run_case(2, 3, 3, 1, 1, 25'h2000, 1'b0, 4'h0, 2);
        // larger block
        run_case(2, 300, 10, 1, 1, 25'h10, 1'b0, 4'h0, -1);
        // random mix
        for (int t = 0; t < 20; t++) begin
            run_case($urandom_range(4, 1), $urandom_range(6, 1), $urandom_range(8, 1),
                     $urandom_range(3, 1), $urandom_range(3, 1),
                     25'($urandom()), 1'($urandom_range(1)), 4'($urandom_range(15)),
                     ($urandom_range(3) == 0) ? 1 : -1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule